// File: doc/BRIEF.md
# MII Receive Status and Error Tracker

This block sits on the receive half of a 4-bit media-independent interface and runs entirely in the receive clock domain. While the data-valid line is high it follows a frame. It finds the start-of-frame delimiter after the preamble. It collects any receive-error assertion into a per-frame error flag. When data-valid drops it reports that flag together with a one-cycle frame-done pulse.

While data-valid is low the error line cannot change frame status. Instead, the error line and the nibble are decoded into three outcomes: plain idle, a false-carrier event, or a reserved code. The block also passes the asynchronous carrier-sense input through a two-flop synchronizer. In full-duplex operation the synchronized carrier sense is forced low, because carrier sense has no use there.

All outputs are registered. Each output describes the inputs sampled at the previous rising clock edge. The carrier-sense output is the exception: it lags its input by two edges.

Top module: `mii_rx_status`

## Requirements
- R1: While `rst` is high at a clock edge, every output register and both carrier-sense synchronizer stages clear, so all outputs read 0 after reset.
- R2: `frame_err` rises after any edge at which `rx_dv` and `rx_er` are both high. It then stays high for the remainder of that frame.
- R3: An edge with `rx_dv` low leaves `frame_err` unchanged, whatever `rx_er` and `rx_nib` are.
- R4: At the first edge of a new frame (`rx_dv` high after being low), `frame_err` takes the value of `rx_er` at that edge. Errors from earlier frames are discarded.
- R5: `frame_done` is high for exactly the one cycle after the first edge at which `rx_dv` is low following a high. In that cycle `frame_err` shows the final status of the frame that just ended.
- R6: `false_carrier` is high for the cycle after each edge with `rx_dv`=0, `rx_er`=1 and `rx_nib`=4'b1110.
- R7: `reserved_code` is high for the cycle after each edge with `rx_dv`=0, `rx_er`=1 and `rx_nib` equal to 4'b0001 through 4'b1101 or 4'b1111.
- R8: An idle edge with `rx_er`=0, or with `rx_er`=1 and `rx_nib`=4'b0000, raises neither `false_carrier` nor `reserved_code`.
- R9: `sof_seen` rises after an in-frame edge carrying nibble 4'hD when the previous in-frame nibble was 4'h5. It stays high while `rx_dv` stays high and clears after the first edge with `rx_dv` low.
- R10: With `full_duplex`=0, `crs_sync` equals the value `crs_async` had two rising edges earlier.
- R11: With `full_duplex`=1, `crs_sync` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_dv | input | 1 | Receive data valid |
| rx_er | input | 1 | Receive error |
| rx_nib | input | 4 | Receive data nibble |
| crs_async | input | 1 | Carrier sense, asynchronous |
| full_duplex | input | 1 | 1 selects full duplex, which masks carrier sense |
| frame_err | output | 1 | Sticky error status of the current or last frame |
| frame_done | output | 1 | One-cycle pulse when a frame ends |
| sof_seen | output | 1 | Start-of-frame delimiter recognized in the current frame |
| false_carrier | output | 1 | False-carrier code seen during idle |
| reserved_code | output | 1 | Reserved error code seen during idle |
| crs_sync | output | 1 | Synchronized, duplex-gated carrier sense |

## Verification
The frame-end report and the idle decode can land in the same cycle. This happens when the first edge with `rx_dv` low also carries `rx_er` high with a false-carrier or reserved nibble. The bench provokes this at the end of several frames, with error-free and errored bodies. It expects `frame_done` and the idle pulse together. It also expects `frame_err` to keep the in-frame status rather than absorb the idle error. Every cycle is judged against a per-cycle expectation computed from the requirements.

// File: rtl/mii_rx_status.sv
module mii_rx_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_dv,
  input  logic       rx_er,
  input  logic [3:0] rx_nib,
  input  logic       crs_async,
  input  logic       full_duplex,
  output logic       frame_err,
  output logic       frame_done,
  output logic       sof_seen,
  output logic       false_carrier,
  output logic       reserved_code,
  output logic       crs_sync
);

  localparam logic [3:0] NIB_PRE  = 4'h5;
  localparam logic [3:0] NIB_SFD  = 4'hD;
  localparam logic [3:0] NIB_FC   = 4'hE;
  localparam logic [3:0] NIB_IDLE = 4'h0;

  logic dv_q;
  logic pre_q;
  logic crs_s1;
  logic crs_s2;
  logic frame_start;
  logic idle_err;

  assign frame_start = rx_dv & ~dv_q;
  assign idle_err    = ~rx_dv & rx_er;

  always_ff @(posedge clk) begin
    if (rst) begin
      dv_q       <= 1'b0;
      frame_err  <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      dv_q       <= rx_dv;
      frame_done <= dv_q & ~rx_dv;
      if (frame_start)
        frame_err <= rx_er;
      else if (rx_dv)
        frame_err <= frame_err | rx_er;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q    <= 1'b0;
      sof_seen <= 1'b0;
    end else if (!rx_dv) begin
      pre_q    <= 1'b0;
      sof_seen <= 1'b0;
    end else if (frame_start) begin
      pre_q    <= (rx_nib == NIB_PRE);
      sof_seen <= 1'b0;
    end else if (!sof_seen) begin
      pre_q    <= (rx_nib == NIB_PRE);
      sof_seen <= pre_q & (rx_nib == NIB_SFD);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      false_carrier <= 1'b0;
      reserved_code <= 1'b0;
    end else begin
      false_carrier <= idle_err & (rx_nib == NIB_FC);
      reserved_code <= idle_err & (rx_nib != NIB_FC) & (rx_nib != NIB_IDLE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      crs_s1 <= 1'b0;
      crs_s2 <= 1'b0;
    end else begin
      crs_s1 <= crs_async;
      crs_s2 <= crs_s1;
    end
  end

  assign crs_sync = crs_s2 & ~full_duplex;

endmodule

// File: rtl/mii_rx_status_chk.sv
module mii_rx_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       rx_dv,
  input logic       rx_er,
  input logic [3:0] rx_nib,
  input logic       full_duplex,
  input logic       frame_err,
  input logic       frame_done,
  input logic       sof_seen,
  input logic       false_carrier,
  input logic       reserved_code,
  input logic       crs_sync
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R5

  AST_ERR_HELD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rx_dv |=> $stable(frame_err)); // R3

  AST_IDLE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({false_carrier, reserved_code})); // R7

  AST_FC_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !rx_dv && rx_er && rx_nib == 4'hE |=> false_carrier); // R6

  AST_SOF_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    !rx_dv |=> !sof_seen); // R9

  AST_CRS_DUPLEX: assert property (@(posedge clk) disable iff (rst)
    full_duplex |-> !crs_sync); // R11

endmodule

bind mii_rx_status mii_rx_status_chk u_chk (
  .clk(clk), .rst(rst), .rx_dv(rx_dv), .rx_er(rx_er), .rx_nib(rx_nib),
  .full_duplex(full_duplex), .frame_err(frame_err), .frame_done(frame_done),
  .sof_seen(sof_seen), .false_carrier(false_carrier),
  .reserved_code(reserved_code), .crs_sync(crs_sync)
);

// File: tb/mii_rx_status_test.sv
module mii_rx_status_test;
  logic clk = 0, rst = 1;
  logic rx_dv = 0, rx_er = 0, crs_async = 0, full_duplex = 0;
  logic [3:0] rx_nib = 0;
  logic frame_err, frame_done, sof_seen, false_carrier, reserved_code, crs_sync;

  int checks = 0, failures = 0;
  bit finished = 0;

  bit e_err, e_done, e_sof, e_pre, e_fc, e_rs, e_crs, c1, pdv;

  always #5 clk = ~clk;

  mii_rx_status uut (
    .clk(clk), .rst(rst), .rx_dv(rx_dv), .rx_er(rx_er), .rx_nib(rx_nib),
    .crs_async(crs_async), .full_duplex(full_duplex),
    .frame_err(frame_err), .frame_done(frame_done), .sof_seen(sof_seen),
    .false_carrier(false_carrier), .reserved_code(reserved_code), .crs_sync(crs_sync)
  );

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic check_all(bit dv, bit er, bit [3:0] nib);
    chk(dv ? (pdv ? "R2" : "R4") : "R3", "frame_err", frame_err, e_err);
    chk("R5", "frame_done", frame_done, e_done);
    chk("R9", "sof_seen", sof_seen, e_sof);
    chk((!dv && (!er || nib == 0)) ? "R8" : "R6", "false_carrier", false_carrier, e_fc);
    chk((!dv && (!er || nib == 0)) ? "R8" : "R7", "reserved_code", reserved_code, e_rs);
    chk(full_duplex ? "R11" : "R10", "crs_sync", crs_sync, e_crs);
  endtask

  task automatic step(bit dv, bit er, bit [3:0] nib, bit crs);
    @(negedge clk);
    rx_dv = dv; rx_er = er; rx_nib = nib; crs_async = crs;
    @(posedge clk);
    e_done = pdv && !dv;
    if (dv) begin
      if (!pdv) begin
        e_err = er; e_pre = (nib == 4'h5); e_sof = 0;
      end else begin
        e_err = e_err | er;
        if (!e_sof) begin
          e_sof = e_pre && (nib == 4'hD);
          e_pre = (nib == 4'h5);
        end
      end
    end else begin
      e_sof = 0; e_pre = 0;
    end
    e_fc = !dv && er && (nib == 4'hE);
    e_rs = !dv && er && (nib != 4'hE) && (nib != 4'h0);
    e_crs = c1 && !full_duplex;
    c1 = crs;
    pdv = dv;
    #2;
    check_all(dv, er, nib);
  endtask

  task automatic frame(int npre, bit good_sfd, int len, int err_at, bit [3:0] end_nib, bit end_er);
    for (int i = 0; i < npre; i++) step(1, err_at == -1 && i == 0, 4'h5, i[0]);
    step(1, 0, good_sfd ? 4'hD : 4'h7, 1);
    for (int i = 0; i < len; i++) step(1, i == err_at, 4'((i * 7 + 3) % 16), i[1]);
    step(0, end_er, end_nib, 0);
    step(0, 1, 4'h3, 0);
    step(0, 0, 4'h0, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    // R1: everything cleared by reset
    chk("R1", "frame_err", frame_err, 0);
    chk("R1", "frame_done", frame_done, 0);
    chk("R1", "sof_seen", sof_seen, 0);
    chk("R1", "false_carrier", false_carrier, 0);
    chk("R1", "reserved_code", reserved_code, 0);
    chk("R1", "crs_sync", crs_sync, 0);

    // Idle sweep over error line and all nibbles: R6 R7 R8, R10 carrier pattern
    for (int e = 0; e < 2; e++)
      for (int n = 0; n < 16; n++)
        step(0, e[0], 4'(n), 1'((n * 5 + e) % 3 == 0));

    // Frames: clean, errored mid-body, errored on first cycle, bad delimiter
    frame(7, 1, 10, -2, 4'hE, 1);   // clean frame ends together with false carrier
    frame(7, 1, 10, 4, 4'h9, 1);    // R2 error in body, done with reserved code
    frame(3, 1, 6, -1, 4'hE, 1);    // R4 error on first cycle
    frame(2, 0, 5, -2, 4'h0, 1);    // R9 no delimiter recognized
    frame(1, 1, 3, 2, 4'hF, 1);     // R2 short frame

    // R4: back-to-back frames, error cleared at new frame start
    step(1, 1, 4'h5, 0);
    step(1, 0, 4'hD, 0);
    step(0, 1, 4'hE, 1);
    step(1, 0, 4'h5, 1);
    step(1, 0, 4'hD, 0);
    step(1, 0, 4'h1, 0);
    step(0, 0, 4'h0, 0);

    // R3: idle errors do not touch status after an errored frame
    step(1, 1, 4'h5, 0);
    step(0, 1, 4'h2, 0);
    for (int n = 0; n < 16; n++) step(0, 1, 4'(n), n[0]);

    // R11: full duplex masks carrier sense; then back to half duplex (R10)
    full_duplex = 1;
    for (int i = 0; i < 8; i++) step(0, 0, 4'h0, 1);
    full_duplex = 0;
    for (int i = 0; i < 8; i++) step(0, 0, 4'h0, i[0] ^ i[2]);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule